// File: doc/BRIEF.md
# Serial Register Port for a Converter Front End

This block is the serial command interface of a measurement converter, modelled in the fast system-clock domain. The serial clock, chip select and data input are synchronised and their edges detected on the system clock. Every transaction opens with a command byte that names the direction and one of eight register addresses. A data phase follows, whose length (8, 16 or 24 bits) depends on the address. Writes are handed to an external register file over a one-cycle parallel strobe. Read data is taken from that register file, from a fixed identity value, or from an internal ready flag.

A single output carries both the serial read data and, between transfers, the inverted ready flag. A pulse from the conversion logic clears the flag, and a complete read of the result register sets it again. A streaming mode shifts the result register out on each burst of clocks without any command byte. It is left by a specific byte sent on the data input during a burst. A run of 32 consecutive ones on the data input restarts the interface and pulses a reset toward the register file.

Top module: `adc_serial_port`

## Requirements
- R1: While the interface waits for a command and the first command bit (bit 7) arrives as 1, no bit is taken in. A command preceded by up to 31 such ones is decoded normally and causes no interface reset.
- R2: A command byte is sent MSB first: bit 7 = 0, bit 6 = direction (1 read), bits 5..3 = address, bit 2 = streaming request, bits 1..0 = 0. A byte with nonzero bits 1..0 is discarded. A write to address 1 or 2 takes 16 data bits, to 5 takes 8, and to 6 or 7 takes 24. When the data phase ends, the block gives a one-cycle `reg_wr_o` with that address and the value right-aligned.
- R3: Read data leaves MSB first, changing after the serial clock falls and stable at the next rise. Lengths by address are 0/4/5: 8, 1/2: 16, 3/6/7: 24. Address 4 returns the ID parameter. Address 0 returns the inverted ready flag in bit 7 over `reg_rdata_i[6:0]`.
- R4: Writes to addresses 0, 3 and 4 produce no `reg_wr_o`. A write command to address 0 has no data phase. Writes to 3 or 4 consume their 24 or 8 data bits.
- R5: After a data phase, or after a write command to address 0, the next bits are decoded as a new command with chip select still low.
- R6: With chip select high, `dout_oe_o` is low. Raising chip select part-way through a command discards the partial byte.
- R7: With chip select low and no read in progress, `dout_o` shows the inverted ready flag. It goes low after `conv_done_i` and returns high once all 24 bits of address 3 have been read.
- R8: Command 0x5C enters streaming mode. In this mode a burst starting while ready is low shifts out the 24-bit result, and then sets the flag not-ready. While not ready, bursts are ignored and the line stays high.
- R9: The byte 0x58, sent on the data input during the first 8 clocks of a streaming burst while ready is low, ends streaming mode. The burst itself still completes.
- R10: The 32nd consecutive 1 sampled on the data input, in any state, pulses `soft_rst_o` once. It also leaves streaming mode, sets the flag not-ready and returns to command wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles high |
| csn_i | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out / inverted ready |
| dout_oe_o | output | 1 | Output enable for `dout_o` (low = high-impedance) |
| conv_done_i | input | 1 | One-cycle pulse: new conversion result available |
| reg_addr_o | output | 3 | Register address of the current access |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 24 | Write data, right-aligned |
| reg_rdata_i | input | 24 | Read data for `reg_addr_o`, right-aligned |
| soft_rst_o | output | 1 | One-cycle pulse after 32 consecutive ones |

## Verification
A wrong bit counter or wrong state shows up at the ports within one transaction. A miscounted data phase either absorbs the next command's bits or leaves bits behind, so the readback that follows returns a shifted value. A ready flag left in the wrong state shows on `dout_o` as soon as chip select drops with no transfer running, or as a streaming burst that repeats old data instead of returning all ones. A ones counter that triggers early or late is caught by the 31-ones preamble, which must do nothing, and by the streaming exit sequence, which must reset the port.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter logic [7:0] ID_VAL     = 8'h49,
  parameter int         ONES_LIMIT = 32,
  parameter int         DW         = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          csn_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic          dout_oe_o,
  input  logic          conv_done_i,
  output logic [2:0]    reg_addr_o,
  output logic          reg_wr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          soft_rst_o
);
  localparam int CW = $clog2(DW + 1);
  localparam int OW = $clog2(ONES_LIMIT + 1);

  typedef enum logic [1:0] {S_CMD, S_WR, S_RD} st_t;

  logic [2:0]    sclk_sr;
  logic [1:0]    csn_sr, din_sr;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [6:0]    cmd;
  logic [2:0]    addr_q;
  logic [DW-1:0] sh;
  logic          rdy_n, cont;
  logic [OW-1:0] ones;

  function automatic logic [CW-1:0] len_of(input logic [2:0] a);
    case (a)
      3'd1, 3'd2:       len_of = CW'(16);
      3'd3, 3'd6, 3'd7: len_of = CW'(DW);
      default:          len_of = CW'(8);
    endcase
  endfunction

  wire           csn_s    = csn_sr[1];
  wire           din_s    = din_sr[1];
  wire           rise     = !csn_s && sclk_sr[1] && !sclk_sr[2];
  wire           fall     = !csn_s && !sclk_sr[1] && sclk_sr[2];
  wire [7:0]     cbyte    = {cmd, din_s};
  wire [CW-1:0]  cur_len  = len_of(addr_q);
  wire           last_bit = (cnt == cur_len - 1'b1);
  wire           ones_hit = rise && din_s && (ones == OW'(ONES_LIMIT - 1));
  wire           wr_ok    = (addr_q == 3'd1) || (addr_q == 3'd2) || (addr_q == 3'd5) ||
                            (addr_q == 3'd6) || (addr_q == 3'd7);

  logic [DW-1:0] rd_word;
  always_comb begin
    if (addr_q == 3'd4)       rd_word = {ID_VAL, {(DW-8){1'b0}}};
    else if (addr_q == 3'd0)  rd_word = {rdy_n, reg_rdata_i[6:0], {(DW-8){1'b0}}};
    else if (cur_len == CW'(8))  rd_word = {reg_rdata_i[7:0], {(DW-8){1'b0}}};
    else if (cur_len == CW'(16)) rd_word = {reg_rdata_i[15:0], {(DW-16){1'b0}}};
    else                      rd_word = reg_rdata_i;
  end

  assign reg_addr_o = addr_q;
  assign dout_oe_o  = !csn_s;
  assign dout_o     = (st == S_RD) ? sh[DW-1] : rdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr <= 3'b111;
      csn_sr  <= 2'b11;
      din_sr  <= 2'b00;
    end else begin
      sclk_sr <= {sclk_sr[1:0], sclk_i};
      csn_sr  <= {csn_sr[0], csn_i};
      din_sr  <= {din_sr[0], din_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CMD; cnt <= '0; cmd <= '0; addr_q <= '0; sh <= '0;
      rdy_n <= 1'b1; cont <= 1'b0; ones <= '0;
      reg_wr_o <= 1'b0; reg_wdata_o <= '0; soft_rst_o <= 1'b0;
    end else begin
      reg_wr_o   <= 1'b0;
      soft_rst_o <= 1'b0;
      if (csn_s) begin
        st  <= S_CMD;
        cnt <= '0;
        cmd <= '0;
      end else if (ones_hit) begin
        st <= S_CMD; cnt <= '0; cmd <= '0; addr_q <= '0;
        rdy_n <= 1'b1; cont <= 1'b0; ones <= '0;
        soft_rst_o <= 1'b1;
      end else begin
        if (rise) ones <= din_s ? ones + 1'b1 : '0;
        case (st)
          S_CMD: begin
            if (!cont) begin
              if (rise && !(cnt == '0 && din_s)) begin
                if (cnt == CW'(7)) begin
                  cnt <= '0;
                  cmd <= '0;
                  sh  <= '0;
                  if (cbyte[1:0] == 2'b00) begin
                    addr_q <= cbyte[5:3];
                    if (cbyte[6]) begin
                      if (cbyte[5:3] == 3'd3 && cbyte[2]) cont <= 1'b1;
                      else st <= S_RD;
                    end else if (cbyte[5:3] != 3'd0) begin
                      st <= S_WR;
                    end
                  end
                end else begin
                  cmd <= {cmd[5:0], din_s};
                  cnt <= cnt + 1'b1;
                end
              end
            end else if (fall && !rdy_n) begin
              st  <= S_RD;
              sh  <= reg_rdata_i;
              cmd <= '0;
            end
          end
          S_WR: begin
            if (rise) begin
              sh <= {sh[DW-2:0], din_s};
              if (last_bit) begin
                cnt <= '0;
                st  <= S_CMD;
                if (wr_ok) begin
                  reg_wr_o    <= 1'b1;
                  reg_wdata_o <= {sh[DW-2:0], din_s};
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: begin
            if (fall) sh <= (cnt == '0) ? rd_word : {sh[DW-2:0], 1'b0};
            if (rise) begin
              if (cont && cnt < CW'(7)) cmd <= {cmd[5:0], din_s};
              if (cont && cnt == CW'(7) && cbyte == 8'h58 && !rdy_n) cont <= 1'b0;
              if (last_bit) begin
                cnt <= '0;
                cmd <= '0;
                st  <= S_CMD;
                if (addr_q == 3'd3) rdy_n <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        endcase
      end
      if (conv_done_i) rdy_n <= 1'b0;
    end
  end

  // R2
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  // R4
  wr_ro_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> !(reg_addr_o == 3'd0 || reg_addr_o == 3'd3 || reg_addr_o == 3'd4));

  // R7
  ready_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_i |=> (st == S_RD || !dout_o));

  // R10
  soft_rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (st == S_CMD && !cont && cnt == '0));

  // R3
  phase_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_CMD) |-> (cnt < cur_len));

  // R1
  cmd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD) |-> (cnt < CW'(8)));
endmodule

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  localparam logic [7:0] ID = 8'h49;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_i = 1'b1, csn_i = 1'b1, din_i = 1'b0, conv_done_i = 1'b0;
  logic dout_o, dout_oe_o, reg_wr_o, soft_rst_o;
  logic [2:0] reg_addr_o;
  logic [23:0] reg_wdata_o, reg_rdata_i;
  logic [23:0] rf [8];
  logic [23:0] conv_data = 24'h0;
  logic [23:0] mdl [8];
  logic exp_rdy_n;
  int tests = 0, fails = 0, wr_cnt = 0, sr_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_serial_port #(.ID_VAL(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .din_i(din_i),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o), .conv_done_i(conv_done_i),
    .reg_addr_o(reg_addr_o), .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i), .soft_rst_o(soft_rst_o));

  function automatic logic [23:0] dflt(input int a);
    case (a)
      0: dflt = 24'h000008;
      1: dflt = 24'h00000A;
      2: dflt = 24'h000710;
      6: dflt = 24'h800000;
      7: dflt = 24'h500000;
      default: dflt = 24'h0;
    endcase
  endfunction

  function automatic int len_b(input int a);
    if (a == 1 || a == 2) len_b = 16;
    else if (a == 3 || a == 6 || a == 7) len_b = 24;
    else len_b = 8;
  endfunction

  function automatic logic [23:0] mask(input int n);
    mask = (n == 24) ? 24'hFFFFFF : ((24'h1 << n) - 24'h1);
  endfunction

  function automatic logic [23:0] exp_rd(input int a);
    if (a == 4) exp_rd = {16'h0, ID};
    else if (a == 0) exp_rd = {16'h0, exp_rdy_n, mdl[0][6:0]};
    else if (a == 3) exp_rd = conv_data;
    else exp_rd = mdl[a] & mask(len_b(a));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst_o) begin
      for (int i = 0; i < 8; i++) rf[i] <= dflt(i);
    end else if (reg_wr_o) begin
      rf[reg_addr_o] <= reg_wdata_o;
    end
    if (reg_wr_o) wr_cnt <= wr_cnt + 1;
    if (soft_rst_o) sr_cnt <= sr_cnt + 1;
  end

  assign reg_rdata_i = (reg_addr_o == 3'd3) ? conv_data : rf[reg_addr_o];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) mdl[i] = dflt(i);
    exp_rdy_n = 1'b1;
  endtask

  task automatic cs(input logic v);
    @(negedge clk); csn_i = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic o);
    @(negedge clk); sclk_i = 1'b0; din_i = b;
    repeat (HALF) @(negedge clk);
    o = dout_o; sclk_i = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic shift_n(input logic [31:0] v, input int n, output logic [31:0] r);
    logic o;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bit_x(v[i], o);
      r = {r[30:0], o};
    end
  endtask

  task automatic do_write(input int a, input logic [23:0] v);
    logic [31:0] r;
    cs(1'b0);
    shift_n({24'h0, 2'b00, 3'(a), 3'b000}, 8, r);
    if (a != 0) shift_n({8'h0, v}, len_b(a), r);
    cs(1'b1);
    if (a == 1 || a == 2 || a == 5 || a == 6 || a == 7) mdl[a] = v & mask(len_b(a));
  endtask

  task automatic do_read(input int a, output logic [31:0] r);
    cs(1'b0);
    shift_n({24'h0, 2'b01, 3'(a), 3'b000}, 8, r);
    shift_n(32'h0, len_b(a), r);
    cs(1'b1);
    if (a == 3) exp_rdy_n = 1'b1;
  endtask

  task automatic conv(input logic [23:0] v);
    @(negedge clk); conv_data = v; conv_done_i = 1'b1;
    @(negedge clk); conv_done_i = 1'b0;
    repeat (2) @(negedge clk);
    exp_rdy_n = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int addrs [5] = '{1, 2, 5, 6, 7};
    int wc, sc;
    void'($urandom(32'd2024));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R6 reset oe", {31'h0, dout_oe_o}, 32'h0);
    chk("R10 reset strobes", {30'h0, reg_wr_o, soft_rst_o}, 32'h0);
    cs(1'b0);
    chk("R7 reset ready line", {31'h0, dout_o}, 32'h1);
    cs(1'b1);

    // R1 leading ones, and the 31-ones boundary of R10
    sc = sr_cnt;
    cs(1'b0);
    shift_n(32'h7FFFFFFF, 31, r);
    shift_n(32'h60, 8, r);
    shift_n(32'h0, 8, r);
    cs(1'b1);
    chk("R1 ID after 31 leading ones", r, {24'h0, ID});
    chk("R10 no reset at 31 ones", sr_cnt, sc);

    // R2 / R3 random write then readback
    for (int k = 0; k < 30; k++) begin
      int a;
      logic [23:0] v;
      a = addrs[$urandom % 5];
      v = 24'($urandom);
      wc = wr_cnt;
      do_write(a, v);
      chk("R2 one strobe per write", wr_cnt, wc + 1);
      do_read(a, r);
      chk("R3 readback", r, {8'h0, exp_rd(a)});
      if (k % 6 == 0) begin
        do_read(0, r);
        chk("R3 status", r, {8'h0, exp_rd(0)});
      end
    end

    // R2 nonzero low command bits are discarded
    wc = wr_cnt;
    cs(1'b0); shift_n(32'h29, 8, r); cs(1'b1);
    chk("R2 bad command no write", wr_cnt, wc);
    do_read(5, r);
    chk("R2 IO unchanged", r, {8'h0, exp_rd(5)});

    // R4 read-only writes ignored; R5 back-to-back after address 0
    wc = wr_cnt;
    do_write(3, 24'h123456);
    do_write(4, 24'h0000AA);
    cs(1'b0);
    shift_n(32'h00, 8, r);
    shift_n(32'h60, 8, r);
    shift_n(32'h0, 8, r);
    cs(1'b1);
    chk("R5 command after address-0 write", r, {24'h0, ID});
    chk("R4 no strobe for read-only", wr_cnt, wc);

    // R5 back-to-back read then write then read, CS low throughout
    cs(1'b0);
    shift_n(32'h48, 8, r);
    shift_n(32'h0, 16, r);
    chk("R5 first read", r, {16'h0, exp_rd(1)[15:0]});
    shift_n(32'h08, 8, r);
    shift_n(32'h0000BEEF, 16, r);
    mdl[1] = 24'h00BEEF;
    shift_n(32'h48, 8, r);
    shift_n(32'h0, 16, r);
    cs(1'b1);
    chk("R5 chained write", r, 32'h0000BEEF);

    // R6 abort partial command
    cs(1'b0);
    shift_n(32'h2, 4, r);
    cs(1'b1);
    chk("R6 oe low with CS high", {31'h0, dout_oe_o}, 32'h0);
    do_read(4, r);
    chk("R6 clean command after abort", r, {24'h0, ID});

    // R7 ready flag life cycle
    conv(24'hA5C3E1);
    cs(1'b0);
    chk("R7 ready low after conversion", {31'h0, dout_o}, 32'h0);
    cs(1'b1);
    do_read(0, r);
    chk("R3 status shows ready", r, {8'h0, exp_rd(0)});
    do_read(3, r);
    chk("R3 data read", r, 32'h00A5C3E1);
    cs(1'b0);
    chk("R7 not ready after full read", {31'h0, dout_o}, 32'h1);
    cs(1'b1);

    // R8 streaming mode
    cs(1'b0); shift_n(32'h5C, 8, r); cs(1'b1);
    cs(1'b0);
    shift_n(32'h0, 24, r);
    chk("R8 burst ignored while not ready", r, 32'h00FFFFFF);
    cs(1'b1);
    conv(24'h3C0F71);
    cs(1'b0);
    shift_n(32'h0, 24, r);
    chk("R8 streamed result", r, 32'h003C0F71);
    shift_n(32'h0, 24, r);
    chk("R8 result read once", r, 32'h00FFFFFF);
    cs(1'b1);

    // R9 exit streaming with 0x58
    conv(24'h80_0001);
    cs(1'b0);
    shift_n(32'h00580000, 24, r);
    chk("R9 burst completes on exit", r, 32'h00800001);
    cs(1'b1);
    do_read(4, r);
    chk("R9 commands accepted after exit", r, {24'h0, ID});

    // R10 32 ones from streaming mode
    do_write(6, 24'h0F0F0F);
    conv(24'h111111);
    cs(1'b0); shift_n(32'h5C, 8, r); cs(1'b1);
    sc = sr_cnt;
    cs(1'b0);
    shift_n(32'hFFFFFFFF, 32, r);
    cs(1'b1);
    model_reset();
    chk("R10 one reset pulse", sr_cnt, sc + 1);
    cs(1'b0);
    chk("R10 not ready after reset", {31'h0, dout_o}, 32'h1);
    cs(1'b1);
    do_read(4, r);
    chk("R10 streaming left", r, {24'h0, ID});
    do_read(1, r);
    chk("R10 mode default", r, {8'h0, exp_rd(1)});
    do_read(6, r);
    chk("R10 offset default", r, {8'h0, exp_rd(6)});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule